// File: doc/BRIEF.md
# Outbound Address Translation Window Unit

This block keeps a small bank of outbound translation regions and rewrites host addresses through them. Each region carries a 64-bit base, a 32-bit limit that shares the base's upper half, a 64-bit target, a 5-bit transaction kind and an enable bit. A host address that falls inside an enabled region leaves the block rebased onto that region's target and tagged with its kind. An address that hits no region leaves unchanged, with a miss flag set.

Software programs the regions through a 32-bit register port. The register layout is fixed at build time by a parameter. In the indexed layout, one index register picks the region that a shared 32-byte window reaches. In the flat layout, every region has its own 32-byte block and the index register reads as all ones. Software can learn the layout, the total region count and the outbound region count only by reading back what it wrote. Regions at or above `NUM_OUT` exist in the register file but cannot be used outbound. Their lower target word and their enable bit keep no value that is written to them.

Top module: `obxl_unit`

## Requirements
- R1: After reset, every region is disabled with all fields zero, the index register holds 0, `cfg_rdata` is 0 and `xl_out_valid` is 0.
- R2: Indexed layout (`UNROLL`=0): the index register sits at address 0x800. Region fields are reached at offsets 0x00–0x1F of the region the index selects. Offset 0x00 is kind (bits 4:0), 0x04 is enable (bit 31), 0x08 is base low, 0x0C is base high, 0x10 is limit, 0x14 is target low and 0x18 is target high. Other addresses read 0.
- R3: Flat layout (`UNROLL`=1): region r sits at address r·0x20 and uses the same field offsets as R2. Address 0x800 always reads 0xFFFFFFFF and ignores writes. A region number at or above `NUM_REGIONS` reads 0 and keeps nothing.
- R4: Indexed layout: a value written to the index register that is at or above `NUM_REGIONS` is stored as `NUM_REGIONS`−1. Reading the index back after writing 0xFFFFFFFF therefore gives the highest region number.
- R5: For a region numbered `NUM_OUT` or above, the target-low word and the enable bit always read 0, whatever is written to them. For regions below `NUM_OUT`, they read back what was written.
- R6: A value written to the enable bit reads back from a read issued in the cycle after the write.
- R7: An enabled region hits when {base_hi, base_lo} ≤ address ≤ {base_hi, limit}. Both ends are inclusive, and the comparison spans all 64 bits.
- R8: On a hit, `xl_out_addr` = {target_hi, target_lo} + (address − {base_hi, base_lo}) modulo 2^64, `xl_out_kind` is the region's kind and `xl_out_miss` is 0.
- R9: When more than one enabled region hits, the region with the lowest number wins.
- R10: When no region hits, `xl_out_addr` equals the input address, `xl_out_kind` is 0 and `xl_out_miss` is 1.
- R11: The translation result and `xl_out_valid` appear one clock after `xl_in_valid`/`xl_in_addr` are sampled. `cfg_rdata` shows the register at the `cfg_addr` sampled on the previous clock, with the state as it was before any write in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 12 | Register byte address |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Registered read data for the previous cycle's `cfg_addr` |
| xl_in_valid | input | 1 | Host address valid |
| xl_in_addr | input | 64 | Host address to translate |
| xl_out_valid | output | 1 | Translated result valid |
| xl_out_addr | output | 64 | Translated or passed-through address |
| xl_out_kind | output | 5 | Transaction kind of the hit region, 0 on a miss |
| xl_out_miss | output | 1 | No enabled region matched |

## Verification
Every result is due exactly one clock edge after the stimulus that causes it. Read data reflects the address and state sampled at that edge, and a translated address follows its input by one edge. A register write becomes visible to a read presented one cycle later. The bench applies each stimulus on a falling edge and works out the expected value from its own model of the registers before that stimulus's write is applied. It compares the outputs on the next falling edge, so each comparison lands on the single edge where the result is due.

// File: rtl/obxl_unit.sv
module obxl_unit #(
  parameter int NUM_REGIONS = 8,
  parameter int NUM_OUT     = 6,
  parameter bit UNROLL      = 1'b0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [11:0] cfg_addr,
  input  logic [31:0] cfg_wdata,
  output logic [31:0] cfg_rdata,
  input  logic        xl_in_valid,
  input  logic [63:0] xl_in_addr,
  output logic        xl_out_valid,
  output logic [63:0] xl_out_addr,
  output logic [4:0]  xl_out_kind,
  output logic        xl_out_miss
);
  localparam int          IW       = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1;
  localparam logic [11:0] IDX_ADDR = 12'h800;
  localparam logic [4:0]  OF_KIND  = 5'h00;
  localparam logic [4:0]  OF_EN    = 5'h04;
  localparam logic [4:0]  OF_BLO   = 5'h08;
  localparam logic [4:0]  OF_BHI   = 5'h0C;
  localparam logic [4:0]  OF_LIM   = 5'h10;
  localparam logic [4:0]  OF_TLO   = 5'h14;
  localparam logic [4:0]  OF_THI   = 5'h18;

  logic [IW-1:0]          idx_q;
  logic [31:0]            blo_q [NUM_REGIONS];
  logic [31:0]            bhi_q [NUM_REGIONS];
  logic [31:0]            lim_q [NUM_REGIONS];
  logic [31:0]            tlo_q [NUM_REGIONS];
  logic [31:0]            thi_q [NUM_REGIONS];
  logic [4:0]             kind_q[NUM_REGIONS];
  logic [NUM_REGIONS-1:0] en_q;

  logic [5:0] sel;
  logic       win;
  wire  [4:0] off = cfg_addr[4:0];

  if (UNROLL) begin : g_flat
    assign sel = cfg_addr[10:5];
    assign win = !cfg_addr[11] && (32'(cfg_addr[10:5]) < 32'(NUM_REGIONS));
  end else begin : g_indexed
    assign sel = 6'(idx_q);
    assign win = (cfg_addr[11:5] == 7'd0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q <= '0;
    end else if (!UNROLL && cfg_we && cfg_addr == IDX_ADDR) begin
      idx_q <= (cfg_wdata >= 32'(NUM_REGIONS)) ? IW'(NUM_REGIONS - 1) : cfg_wdata[IW-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q <= '0;
      for (int r = 0; r < NUM_REGIONS; r++) begin
        blo_q[r]  <= '0;
        bhi_q[r]  <= '0;
        lim_q[r]  <= '0;
        tlo_q[r]  <= '0;
        thi_q[r]  <= '0;
        kind_q[r] <= '0;
      end
    end else begin
      for (int r = 0; r < NUM_REGIONS; r++) begin
        if (cfg_we && win && sel == 6'(r)) begin
          case (off)
            OF_KIND: kind_q[r] <= cfg_wdata[4:0];
            OF_EN:   en_q[r]   <= (r < NUM_OUT) && cfg_wdata[31];
            OF_BLO:  blo_q[r]  <= cfg_wdata;
            OF_BHI:  bhi_q[r]  <= cfg_wdata;
            OF_LIM:  lim_q[r]  <= cfg_wdata;
            OF_TLO:  if (r < NUM_OUT) tlo_q[r] <= cfg_wdata;
            OF_THI:  thi_q[r]  <= cfg_wdata;
            default: ;
          endcase
        end
      end
    end
  end

  logic [31:0] rd_d;
  always_comb begin
    rd_d = '0;
    if (cfg_addr == IDX_ADDR) begin
      rd_d = UNROLL ? 32'hFFFF_FFFF : 32'(idx_q);
    end else if (win) begin
      for (int r = 0; r < NUM_REGIONS; r++) begin
        if (sel == 6'(r)) begin
          case (off)
            OF_KIND: rd_d = {27'd0, kind_q[r]};
            OF_EN:   rd_d = {en_q[r], 31'd0};
            OF_BLO:  rd_d = blo_q[r];
            OF_BHI:  rd_d = bhi_q[r];
            OF_LIM:  rd_d = lim_q[r];
            OF_TLO:  rd_d = tlo_q[r];
            OF_THI:  rd_d = thi_q[r];
            default: rd_d = '0;
          endcase
        end
      end
    end
  end

  logic [63:0] nxt_addr;
  logic [4:0]  nxt_kind;
  logic        nxt_miss;
  always_comb begin
    nxt_addr = xl_in_addr;
    nxt_kind = '0;
    nxt_miss = 1'b1;
    for (int r = NUM_OUT - 1; r >= 0; r--) begin
      if (en_q[r] && xl_in_addr >= {bhi_q[r], blo_q[r]} && xl_in_addr <= {bhi_q[r], lim_q[r]}) begin
        nxt_addr = {thi_q[r], tlo_q[r]} + (xl_in_addr - {bhi_q[r], blo_q[r]});
        nxt_kind = kind_q[r];
        nxt_miss = 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_rdata    <= '0;
      xl_out_valid <= 1'b0;
      xl_out_addr  <= '0;
      xl_out_kind  <= '0;
      xl_out_miss  <= 1'b0;
    end else begin
      cfg_rdata    <= rd_d;
      xl_out_valid <= xl_in_valid;
      xl_out_addr  <= nxt_addr;
      xl_out_kind  <= nxt_kind;
      xl_out_miss  <= nxt_miss;
    end
  end
endmodule

// File: rtl/obxl_unit_chk.sv
module obxl_unit_chk #(
  parameter int NUM_REGIONS = 8,
  parameter bit UNROLL      = 1'b0
) (
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_we,
  input logic [11:0] cfg_addr,
  input logic [31:0] cfg_wdata,
  input logic [31:0] cfg_rdata,
  input logic        xl_in_valid,
  input logic [63:0] xl_in_addr,
  input logic        xl_out_valid,
  input logic [63:0] xl_out_addr,
  input logic [4:0]  xl_out_kind,
  input logic        xl_out_miss
);
  a_r11_valid_rise: assert property (@(posedge clk) disable iff (!rst_n)
    xl_in_valid |=> xl_out_valid);

  a_r11_valid_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !xl_in_valid |=> !xl_out_valid);

  a_r10_miss_passthru: assert property (@(posedge clk) disable iff (!rst_n)
    (xl_out_valid && xl_out_miss) |-> xl_out_addr == $past(xl_in_addr));

  a_r10_miss_kind_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (xl_out_valid && xl_out_miss) |-> xl_out_kind == 5'd0);

  if (UNROLL) begin : g_flat_chk
    a_r3_index_ones: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_addr == 12'h800 |=> cfg_rdata == 32'hFFFF_FFFF);
  end else begin : g_idx_chk
    a_r4_index_bound: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_addr == 12'h800 |=> cfg_rdata < 32'(NUM_REGIONS));

    a_r4_index_saturate: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && cfg_addr == 12'h800 && cfg_wdata >= 32'(NUM_REGIONS)) ##1 (cfg_addr == 12'h800)
      |=> cfg_rdata == 32'(NUM_REGIONS - 1));
  end
endmodule

bind obxl_unit obxl_unit_chk #(.NUM_REGIONS(NUM_REGIONS), .UNROLL(UNROLL)) u_chk (.*);

// File: tb/obxl_unit_tb.sv
`timescale 1ns/1ps
module obxl_unit_tb;
  localparam int NR = 8;
  localparam int NO = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        l_we = 0, u_we = 0;
  logic [11:0] l_a = 0, u_a = 0;
  logic [31:0] l_wd = 0, u_wd = 0;
  logic [31:0] l_rd, u_rd;
  logic        l_iv = 0, u_iv = 0;
  logic [63:0] l_ia = 0, u_ia = 0;
  logic        l_ov, u_ov, l_om, u_om;
  logic [63:0] l_oa, u_oa;
  logic [4:0]  l_ok, u_ok;

  obxl_unit #(.NUM_REGIONS(NR), .NUM_OUT(NO), .UNROLL(1'b0)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(l_we), .cfg_addr(l_a), .cfg_wdata(l_wd),
    .cfg_rdata(l_rd), .xl_in_valid(l_iv), .xl_in_addr(l_ia), .xl_out_valid(l_ov),
    .xl_out_addr(l_oa), .xl_out_kind(l_ok), .xl_out_miss(l_om));

  obxl_unit #(.NUM_REGIONS(NR), .NUM_OUT(NO), .UNROLL(1'b1)) u_dut_flat (
    .clk(clk), .rst_n(rst_n), .cfg_we(u_we), .cfg_addr(u_a), .cfg_wdata(u_wd),
    .cfg_rdata(u_rd), .xl_in_valid(u_iv), .xl_in_addr(u_ia), .xl_out_valid(u_ov),
    .xl_out_addr(u_oa), .xl_out_kind(u_ok), .xl_out_miss(u_om));

  int total = 0;
  int bad = 0;
  bit done = 0;

  logic [31:0] mblo[2][NR], mbhi[2][NR], mlim[2][NR], mtlo[2][NR], mthi[2][NR];
  logic [4:0]  mkind[2][NR];
  bit          men[2][NR];
  int          midx = 0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] m_read(input int m, input logic [11:0] a);
    int r;
    if (a == 12'h800) return (m == 1) ? 32'hFFFF_FFFF : 32'(midx);
    if (a[11]) return 32'd0;
    if (m == 1) r = int'(a[10:5]);
    else begin
      if (a[10:5] != 6'd0) return 32'd0;
      r = midx;
    end
    if (r >= NR) return 32'd0;
    case (a[4:0])
      5'h00: return {27'd0, mkind[m][r]};
      5'h04: return {men[m][r], 31'd0};
      5'h08: return mblo[m][r];
      5'h0C: return mbhi[m][r];
      5'h10: return mlim[m][r];
      5'h14: return mtlo[m][r];
      5'h18: return mthi[m][r];
      default: return 32'd0;
    endcase
  endfunction

  task automatic m_write(input int m, input logic [11:0] a, input logic [31:0] d);
    int r;
    if (a == 12'h800) begin
      if (m == 0) midx = (d >= NR) ? NR - 1 : int'(d);
      return;
    end
    if (a[11]) return;
    if (m == 1) r = int'(a[10:5]);
    else begin
      if (a[10:5] != 6'd0) return;
      r = midx;
    end
    if (r >= NR) return;
    case (a[4:0])
      5'h00: mkind[m][r] = d[4:0];
      5'h04: men[m][r] = (r < NO) && d[31];
      5'h08: mblo[m][r] = d;
      5'h0C: mbhi[m][r] = d;
      5'h10: mlim[m][r] = d;
      5'h14: if (r < NO) mtlo[m][r] = d;
      5'h18: mthi[m][r] = d;
      default: ;
    endcase
  endtask

  task automatic m_xlate(input int m, input logic [63:0] a, output logic [63:0] o,
                         output logic [4:0] k, output bit miss);
    o = a; k = 5'd0; miss = 1'b1;
    for (int r = 0; r < NO; r++) begin
      if (men[m][r] && a >= {mbhi[m][r], mblo[m][r]} && a <= {mbhi[m][r], mlim[m][r]}) begin
        o = {mthi[m][r], mtlo[m][r]} + (a - {mbhi[m][r], mblo[m][r]});
        k = mkind[m][r];
        miss = 1'b0;
        return;
      end
    end
  endtask

  task automatic step(input int m, input bit we, input logic [11:0] a, input logic [31:0] d,
                      input bit iv, input logic [63:0] ia, input string rtag);
    logic [31:0] er;
    logic [63:0] eo;
    logic [4:0]  ek;
    bit          em;
    string       xt;
    if (m == 0) begin
      l_we = we; l_a = a; l_wd = d; l_iv = iv; l_ia = ia;
      u_we = 0; u_a = 12'h800; u_wd = 0; u_iv = 0; u_ia = 0;
    end else begin
      u_we = we; u_a = a; u_wd = d; u_iv = iv; u_ia = ia;
      l_we = 0; l_a = 12'h800; l_wd = 0; l_iv = 0; l_ia = 0;
    end
    er = m_read(m, a);
    m_xlate(m, ia, eo, ek, em);
    @(posedge clk);
    @(negedge clk);
    chk(rtag, (m == 0) ? l_rd : u_rd, er);
    chk("R11", (m == 0) ? l_ov : u_ov, iv);
    if (iv) begin
      xt = em ? "R10" : "R8";
      chk(xt, (m == 0) ? l_oa : u_oa, eo);
      chk(xt, (m == 0) ? l_ok : u_ok, ek);
      chk("R7", (m == 0) ? l_om : u_om, em);
    end
    if (we) m_write(m, a, d);
  endtask

  task automatic wr(input int m, input logic [11:0] a, input logic [31:0] d, input string tag);
    step(m, 1'b1, a, d, 1'b0, 64'd0, tag);
  endtask

  task automatic rd(input int m, input logic [11:0] a, input string tag);
    step(m, 1'b0, a, 32'd0, 1'b0, 64'd0, tag);
  endtask

  task automatic xl(input int m, input logic [63:0] ia);
    step(m, 1'b0, 12'h800, 32'd0, 1'b1, ia, (m == 1) ? "R3" : "R4");
  endtask

  task automatic prog(input int m, input logic [11:0] blk, input logic [31:0] blo, input logic [31:0] bhi,
                      input logic [31:0] lim, input logic [31:0] tlo, input logic [31:0] thi,
                      input logic [4:0] kind, input bit en);
    wr(m, blk + 12'h08, blo, "R2");
    wr(m, blk + 12'h0C, bhi, "R2");
    wr(m, blk + 12'h10, lim, "R2");
    wr(m, blk + 12'h14, tlo, "R2");
    wr(m, blk + 12'h18, thi, "R2");
    wr(m, blk + 12'h00, {27'd0, kind}, "R2");
    wr(m, blk + 12'h04, {en, 31'd0}, "R6");
  endtask

  initial begin
    for (int m = 0; m < 2; m++)
      for (int r = 0; r < NR; r++) begin
        mblo[m][r] = 0; mbhi[m][r] = 0; mlim[m][r] = 0; mtlo[m][r] = 0;
        mthi[m][r] = 0; mkind[m][r] = 0; men[m][r] = 0;
      end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk("R1", l_ov, 1'b0);
    chk("R1", l_rd, 32'd0);
    rd(0, 12'h800, "R1");
    rd(0, 12'h004, "R1");
    xl(0, 64'h0000_0000_1000_0000);

    // R2 indexed layout, region 2
    wr(0, 12'h800, 32'd2, "R2");
    rd(0, 12'h800, "R2");
    prog(0, 12'h000, 32'h1000_0000, 32'h0, 32'h1000_FFFF, 32'h4000_0000, 32'h1, 5'd0, 1'b1);
    rd(0, 12'h008, "R2");
    rd(0, 12'h010, "R2");
    rd(0, 12'h014, "R2");
    rd(0, 12'h018, "R2");
    rd(0, 12'h004, "R6");
    rd(0, 12'h01C, "R2");
    rd(0, 12'h020, "R2");
    // R7 inclusive ends, R8 rebase
    xl(0, 64'h0000_0000_1000_0000);
    xl(0, 64'h0000_0000_1000_FFFF);
    xl(0, 64'h0000_0000_1001_0000);
    xl(0, 64'h0000_0000_0FFF_FFFF);
    xl(0, 64'h0000_0000_1000_1234);

    // R4 saturating index
    wr(0, 12'h800, 32'hFFFF_FFFF, "R4");
    rd(0, 12'h800, "R4");
    wr(0, 12'h800, 32'd8, "R4");
    rd(0, 12'h800, "R4");

    // R5 non-outbound regions drop target low and enable
    wr(0, 12'h800, 32'd6, "R5");
    wr(0, 12'h014, 32'h1234_0000, "R5");
    rd(0, 12'h014, "R5");
    wr(0, 12'h004, 32'h8000_0000, "R5");
    rd(0, 12'h004, "R5");
    wr(0, 12'h018, 32'hCAFE_0001, "R5");
    rd(0, 12'h018, "R5");
    wr(0, 12'h800, 32'd5, "R5");
    wr(0, 12'h014, 32'h1234_0000, "R5");
    rd(0, 12'h014, "R5");

    // R9 lowest region wins on overlap
    wr(0, 12'h800, 32'd0, "R9");
    prog(0, 12'h000, 32'h1000_0000, 32'h0, 32'h1000_00FF, 32'h2000_0000, 32'h0, 5'd2, 1'b1);
    xl(0, 64'h0000_0000_1000_0010);
    xl(0, 64'h0000_0000_1000_0100);

    // R7 upper half of base joins the limit
    wr(0, 12'h800, 32'd1, "R7");
    prog(0, 12'h000, 32'h8000_0000, 32'h5, 32'h8FFF_FFFF, 32'h0, 32'h0, 5'd4, 1'b1);
    xl(0, 64'h0000_0005_8000_0004);
    xl(0, 64'h0000_0005_8FFF_FFFF);
    xl(0, 64'h0000_0006_8000_0004);
    xl(0, 64'h0000_0004_8000_0004);

    // R6 disabling region 0 falls back to region 2
    wr(0, 12'h800, 32'd0, "R6");
    wr(0, 12'h004, 32'h0, "R6");
    rd(0, 12'h004, "R6");
    xl(0, 64'h0000_0000_1000_0010);

    // R3 flat layout
    rd(1, 12'h800, "R3");
    wr(1, 12'h800, 32'd3, "R3");
    rd(1, 12'h800, "R3");
    prog(1, 12'h060, 32'h0000_1000, 32'h0, 32'h0000_1FFF, 32'hF000_0000, 32'h7, 5'd5, 1'b1);
    prog(1, 12'h080, 32'h0000_1800, 32'h0, 32'h0000_27FF, 32'hA000_0000, 32'h0, 5'd0, 1'b1);
    rd(1, 12'h068, "R3");
    rd(1, 12'h090, "R3");
    rd(1, 12'h084, "R6");
    rd(1, 12'h000, "R3");
    xl(1, 64'h0000_0000_0000_1900);
    xl(1, 64'h0000_0000_0000_2000);
    xl(1, 64'h0000_0000_0000_2800);
    wr(1, 12'h0D4, 32'h1234_0000, "R5");
    rd(1, 12'h0D4, "R5");
    wr(1, 12'h0B4, 32'h1234_0000, "R5");
    rd(1, 12'h0B4, "R5");
    wr(1, 12'h128, 32'h5555_AAAA, "R3");
    rd(1, 12'h128, "R3");
    // R10 miss after all flat regions disabled
    wr(1, 12'h064, 32'h0, "R6");
    wr(1, 12'h084, 32'h0, "R6");
    xl(1, 64'hFFFF_FFFF_0000_1900);
    xl(1, 64'h0000_0000_0000_1900);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule